// File: doc/BRIEF.md
# Wilkinson Conversion Cycle Sequencer

This block runs one analog-to-digital conversion pass of a ramp-compare (Wilkinson) converter array once a trigger has been accepted. A single-cycle start pulse freezes the sampling array. The block then emits a short clear burst to the per-cell data registers and to the shared Gray-code counter. After a settling gap it enables the ramp together with the counter clock. It holds both on for exactly one full count period of the 12-bit counter.

When the count period ends, the ramp discharges and the counter clock stops. A one-cycle done flag then launches the readout stage. The flag is bit 12 of a 16-bit cycle counter, and that counter clears itself on the following clock. An external event-clear input can also zero the counter at any time. The array stays in hold until the readout stage reports that it has finished. A start pulse that arrives during a conversion has no effect.

Top module: `conv_sequencer`

## Requirements
- R1: While reset is high and in the cycle after it, every output (hold_o, data_clr_o, cnt_clr_o, ramp_o, gck_en_o, done_o) is 0.
- R2: A start pulse sampled while idle sets hold_o (1 = hold, 0 = sample) on the next cycle. hold_o stays 1 until xfer_done_i is sampled high after done, and it is 0 from the cycle after that sample.
- R3: data_clr_o and cnt_clr_o are both 1 for exactly CLR_LEN (default 2) cycles, starting the same cycle that hold_o rises.
- R4: ramp_o (1 = ramp, 0 = discharge) and gck_en_o rise SETTLE (default 3) cycles after the clears fall, and they never overlap the clears.
- R5: Without an event clear, ramp_o and gck_en_o stay 1 for exactly 2**ADC_BITS (4096) consecutive cycles.
- R6: done_o is bit ADC_BITS (12) of the 16-bit cycle counter. It is 1 for exactly the one cycle after ramp_o falls, and the counter is cleared on the next clock.
- R7: evt_clear_i zeroes the cycle counter. Sampled during the ramp, it restarts the window, so ramp_o falls 4096 clocks after the last edge that sampled the clear.
- R8: A start pulse sampled while a conversion or its hold phase is in progress is ignored. It causes no new clear burst, and it changes neither the ramp length nor the hold release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle trigger to begin a conversion |
| evt_clear_i | input | 1 | External clear of the cycle counter |
| xfer_done_i | input | 1 | Readout stage finished; releases hold |
| hold_o | output | 1 | 1 = array holds, 0 = array samples |
| data_clr_o | output | 1 | Clear for per-cell data registers |
| cnt_clr_o | output | 1 | Clear for the Gray-code counter |
| ramp_o | output | 1 | 1 = ramp running, 0 = ramp discharged |
| gck_en_o | output | 1 | Counter clock enable, one count per clock |
| done_o | output | 1 | One-cycle conversion-complete flag |

## Verification
A wrong phase or timer value shows up within a few cycles of start as misplaced clear or ramp edges. The bench samples those edges on the exact cycle where they are due. A cycle counter that is off by even one count moves the falling edge of the ramp and the done pulse. Both are compared on their exact cycles, and on the cycle before, with and without a mid-ramp event clear. A phase machine that reacts to a stray start shows a fresh clear burst, or a changed ramp end, within two cycles of that start.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_CLEAR  = 3'd1,
    PH_SETTLE = 3'd2,
    PH_RAMP   = 3'd3,
    PH_DONE   = 3'd4,
    PH_WAIT   = 3'd5
  } phase_t;
endpackage

// File: rtl/cs_cycle_ctr.sv
module cs_cycle_ctr #(
  parameter int CNT_W    = 16,
  parameter int ADC_BITS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic inc_i,
  output logic tc_o,
  output logic done_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << ADC_BITS;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt <= '0;
    else if (inc_i)     cnt <= cnt + CNT_W'(1);
  end

  // last increment of the window: low field saturated, done bit not yet set
  assign tc_o   = inc_i && !clear_i && (&cnt[ADC_BITS-1:0]) && !cnt[ADC_BITS];
  assign done_o = cnt[ADC_BITS];

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
  // R6
  done_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !inc_i) |=> !done_o || $past(inc_i));
endmodule

// File: rtl/cs_phase_fsm.sv
module cs_phase_fsm
  import conv_seq_pkg::*;
#(
  parameter int CLR_LEN = 2,
  parameter int SETTLE  = 3
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  logic   xfer_done_i,
  input  logic   tc_i,
  output phase_t phase_o,
  output logic   hold_o,
  output logic   data_clr_o,
  output logic   cnt_clr_o,
  output logic   ramp_o,
  output logic   gck_en_o,
  output logic   inc_o,
  output logic   ctr_clr_o
);
  localparam int MAXW  = (CLR_LEN > SETTLE) ? CLR_LEN : SETTLE;
  localparam int TMR_W = $clog2(MAXW + 1);

  phase_t           phase;
  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      tmr        <= '0;
      hold_o     <= 1'b0;
      data_clr_o <= 1'b0;
      cnt_clr_o  <= 1'b0;
      ramp_o     <= 1'b0;
      gck_en_o   <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (start_i) begin
          phase      <= PH_CLEAR;
          tmr        <= TMR_W'(CLR_LEN - 1);
          hold_o     <= 1'b1;
          data_clr_o <= 1'b1;
          cnt_clr_o  <= 1'b1;
        end
        PH_CLEAR: if (tmr == '0) begin
          phase      <= PH_SETTLE;
          tmr        <= TMR_W'(SETTLE - 1);
          data_clr_o <= 1'b0;
          cnt_clr_o  <= 1'b0;
        end else begin
          tmr <= tmr - TMR_W'(1);
        end
        PH_SETTLE: if (tmr == '0) begin
          phase    <= PH_RAMP;
          ramp_o   <= 1'b1;
          gck_en_o <= 1'b1;
        end else begin
          tmr <= tmr - TMR_W'(1);
        end
        PH_RAMP: if (tc_i) begin
          phase    <= PH_DONE;
          ramp_o   <= 1'b0;
          gck_en_o <= 1'b0;
        end
        PH_DONE: phase <= PH_WAIT;
        PH_WAIT: if (xfer_done_i) begin
          phase  <= PH_IDLE;
          hold_o <= 1'b0;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign phase_o   = phase;
  assign inc_o     = (phase == PH_RAMP);
  assign ctr_clr_o = (phase == PH_DONE);

  // R4
  clr_ramp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !((data_clr_o || cnt_clr_o) && ramp_o));
  // R2
  ramp_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ramp_o |-> hold_o);
  // R3
  clr_with_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_clr_o) |-> $rose(hold_o));
  // R8
  clr_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cnt_clr_o) |-> $past(phase) == PH_IDLE);
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADC_BITS = 12,
  parameter int CLR_LEN  = 2,
  parameter int SETTLE   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic evt_clear_i,
  input  logic xfer_done_i,
  output logic hold_o,
  output logic data_clr_o,
  output logic cnt_clr_o,
  output logic ramp_o,
  output logic gck_en_o,
  output logic done_o
);
  phase_t phase;
  logic   tc, inc, ctr_clr;

  cs_phase_fsm #(.CLR_LEN(CLR_LEN), .SETTLE(SETTLE)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .xfer_done_i (xfer_done_i),
    .tc_i        (tc),
    .phase_o     (phase),
    .hold_o      (hold_o),
    .data_clr_o  (data_clr_o),
    .cnt_clr_o   (cnt_clr_o),
    .ramp_o      (ramp_o),
    .gck_en_o    (gck_en_o),
    .inc_o       (inc),
    .ctr_clr_o   (ctr_clr)
  );

  cs_cycle_ctr #(.CNT_W(CNT_W), .ADC_BITS(ADC_BITS)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .clear_i (ctr_clr || evt_clear_i),
    .inc_i   (inc),
    .tc_o    (tc),
    .done_o  (done_o)
  );

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && phase == PH_DONE) |=> !done_o);
  // R6
  done_after_ramp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $fell(ramp_o));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> !(ramp_o || data_clr_o || gck_en_o));
endmodule

// File: tb/conv_sequencer_test.sv
module conv_sequencer_test;
  localparam int WIN = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, evt_clear_i = 1'b0, xfer_done_i = 1'b0;
  logic hold_o, data_clr_o, cnt_clr_o, ramp_o, gck_en_o, done_o;

  always #10 clk = ~clk;

  conv_sequencer uut (
    .clk(clk), .rst(rst), .start_i(start_i), .evt_clear_i(evt_clear_i),
    .xfer_done_i(xfer_done_i), .hold_o(hold_o), .data_clr_o(data_clr_o),
    .cnt_clr_o(cnt_clr_o), .ramp_o(ramp_o), .gck_en_o(gck_en_o), .done_o(done_o)
  );

  typedef struct {
    int       cyc;
    logic [5:0] exp;
    string    tag;
  } item_t;

  item_t q[$];
  int t = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always @(posedge clk) t <= t + 1;

  // vector layout {hold, data_clr, cnt_clr, ramp, gck_en, done}
  task automatic expect_at(input int c, input logic [5:0] e, input string tag);
    item_t it;
    it.cyc = c; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    logic [5:0] got;
    got = {hold_o, data_clr_o, cnt_clr_o, ramp_o, gck_en_o, done_o};
    while (q.size() > 0 && q[0].cyc <= t) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (it.cyc < t || got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b at cycle %0d (due %0d)",
                 it.tag, got, it.exp, t, it.cyc);
      end
    end
  end

  task automatic wait_until(input int c);
    while (t < c) @(negedge clk);
  endtask

  task automatic pulse(ref logic s, input int edge_no);
    wait_until(edge_no - 1);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  // ev_off: edge offset of event clear (0 = none); stray: add ignored starts
  task automatic run_conv(input int ev_off, input bit stray);
    int e, rend, x;
    @(negedge clk);
    e = t + 1;
    rend = (ev_off > 0) ? e + ev_off + WIN : e + 5 + WIN;
    x = rend + 10;
    expect_at(e,       6'b111000, "R2/R3 hold and clears rise");
    expect_at(e + 1,   6'b111000, "R3 clears second cycle");
    expect_at(e + 2,   6'b100000, "R3 clears fall");
    expect_at(e + 4,   6'b100000, "R4 settle gap");
    expect_at(e + 5,   6'b100110, "R4 ramp rises");
    if (ev_off > 0)
      expect_at(e + 5 + WIN, 6'b100110, "R7 ramp extended by event clear");
    if (stray)
      expect_at(e + 51, 6'b100110, "R8 start during ramp ignored");
    expect_at(rend - 1, 6'b100110, "R5 ramp last cycle");
    expect_at(rend,     6'b100001, "R6 ramp falls, done pulse");
    expect_at(rend + 1, 6'b100000, "R6 done one cycle");
    expect_at(x - 1,    6'b100000, "R2 hold kept until transfer done");
    expect_at(x,        6'b000000, "R2 hold released");
    if (stray)
      expect_at(x + 3,  6'b000000, "R8 start during wait ignored");
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (stray) pulse(start_i, e + 50);
    if (ev_off > 0) pulse(evt_clear_i, e + ev_off);
    if (stray) pulse(start_i, rend + 3);
    pulse(xfer_done_i, x);
    wait_until(x + 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_at(t, 6'b000000, "R1 outputs low in reset");
    @(negedge clk);
    rst = 1'b0;
    expect_at(t + 1, 6'b000000, "R1 outputs low after reset");
    wait_until(t + 3);
    run_conv(0, 1'b0);
    run_conv(100, 1'b0);
    run_conv(0, 1'b1);
    wait_until(t + 2);
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule